// File: doc/BRIEF.md
# One-Bit Quadrature Digital Downconverter

This block brings a 1-bit oversampled stream from a wideband band-pass delta-sigma modulator down to baseband. Each accepted sample is multiplied by two square-wave local oscillators that are a quarter period apart. Because both the data and the oscillators are single bits, each product is one XNOR gate. The two products are then low-pass filtered and decimated into signed in-phase and quadrature words.

The filter has two stages. The first is a first-order integrate-and-dump stage with an 8-bit datapath. It turns every block of R products into one block sum. The second is a second-order integrate/comb section with a 15-bit datapath that runs at the block rate. Its combs use a differential delay of two, so the net response is y[n] = b[n] + 2·b[n-1] + b[n-2]. The accumulators wrap in two's complement and the combs recover the exact value. A 2-bit selector chooses R. One I word and one Q word leave together under a single one-cycle strobe.

Top module: `quad_ddc_1b`

## Requirements
- R1: While `rst_n` is low at a rising edge (synchronous, active low), `out_valid` becomes 0, both outputs become 0, the oscillator phase returns to 0, the block counter clears and all filter history is zeroed.
- R2: The in-phase oscillator over phases 0..7 is 1,1,1,1,0,0,0,0. The in-phase product is +1 when `in_bit` equals the oscillator bit and -1 otherwise.
- R3: The quadrature oscillator over phases 0..7 is 1,1,0,0,0,0,1,1. The quadrature product uses the same ±1 rule as R2.
- R4: The phase and the block count advance only on cycles with `in_valid` high. A cycle with `in_valid` low changes neither the filter state nor the outputs.
- R5: `dec_sel` 0,1,2,3 selects R = 4, 8, 16, 32. `out_valid` is high for exactly one cycle, in the cycle after the edge that takes the R-th valid sample of a block, and is high at no other time.
- R6: The first stage delivers b[n], the sum of the ±1 products over the n-th block of R valid samples.
- R7: On each output strobe the branch word is b[n] + 2·b[n-1] + b[n-2] as a 15-bit two's-complement value. Blocks before the first one after reset count as 0.
- R8: The I and Q words are updated on the same edge. Both keep their value until the next strobe.
- R9: `dec_sel` is sampled during reset and at the edge that ends a block. A change in the middle of a block takes effect from the following block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_bit | input | 1 | Modulator output bit (1 = +1, 0 = -1) |
| in_valid | input | 1 | Qualifies `in_bit` on this cycle |
| dec_sel | input | 2 | Decimation select: R = 4 << dec_sel |
| i_out | output | 15 | Signed in-phase baseband word |
| q_out | output | 15 | Signed quadrature baseband word |
| out_valid | output | 1 | One-cycle strobe for `i_out` and `q_out` |

## Verification
The checker watches four things on every cycle. A strobe never lasts two cycles, and it never follows a cycle without an input sample. Both output words hold steady between strobes. Every word stays within the ±4·32 range the filter can produce. The exact oscillator patterns, the block sums, the weighted combination of three blocks and the point at which a new ratio takes effect can only be shown by the bench. It sweeps every ratio with oscillator-matched, constant, gapped and pseudo-random streams and compares each word with the arithmetic of R2, R3, R6 and R7.

// File: rtl/quad_ddc_pkg.sv
package quad_ddc_pkg;
    localparam int SEL_W     = 2;
    localparam int RATIO_W   = 6;
    localparam int CNT_W     = RATIO_W - 1;
    localparam int PH_W      = 3;
    localparam int MAX_RATIO = 32;
    localparam int NUM_BR    = 2;

    // decimation ratio from the select field: 4, 8, 16, 32
    function automatic logic [RATIO_W-1:0] ratio_of(input logic [SEL_W-1:0] sel);
        return RATIO_W'(4) << sel;
    endfunction
endpackage

// File: rtl/ddc_lo_mixer.sv
module ddc_lo_mixer
    import quad_ddc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_bit,
    output logic [NUM_BR-1:0] prod_pos
);
    logic [PH_W-1:0] phase_d, phase_q;
    logic            lo_i, lo_q;

    always_comb begin
        phase_d = phase_q;
        if (in_valid) phase_d = phase_q + PH_W'(1);
        // in-phase: high for the first half period
        lo_i = ~phase_q[2];
        // quadrature: high on phases 0,1,6,7
        lo_q = ~(phase_q[2] ^ phase_q[1]);
        prod_pos[0] = ~(in_bit ^ lo_i);
        prod_pos[1] = ~(in_bit ^ lo_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/ddc_block_ctrl.sv
module ddc_block_ctrl
    import quad_ddc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SEL_W-1:0] dec_sel,
    output logic             blk_end
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  last;

    always_comb begin
        ctl_d   = ctl_q;
        last    = (ctl_q.cnt == CNT_W'(ratio_of(ctl_q.sel) - 1'b1));
        blk_end = in_valid && last;
        if (in_valid) begin
            if (last) begin
                ctl_d.cnt = '0;
                ctl_d.sel = dec_sel;
            end else begin
                ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.cnt <= '0;
            ctl_q.sel <= dec_sel;
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/ddc_int_dump.sv
module ddc_int_dump #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         prod_pos,
    input  logic         blk_end,
    output logic [W-1:0] blk_sum
);
    typedef struct packed {
        logic [W-1:0] acc;
        logic [W-1:0] mark;
    } s1_t;

    s1_t          s1_d, s1_q;
    logic [W-1:0] acc_nx;

    always_comb begin
        s1_d    = s1_q;
        acc_nx  = prod_pos ? s1_q.acc + W'(1) : s1_q.acc - W'(1);
        blk_sum = acc_nx - s1_q.mark;
        if (in_valid) s1_d.acc  = acc_nx;
        if (blk_end)  s1_d.mark = acc_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s1_q <= '0;
        else        s1_q <= s1_d;
    end
endmodule

// File: rtl/ddc_smooth2.sv
module ddc_smooth2 #(
    parameter int IN_W = 8,
    parameter int W    = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            blk_end,
    input  logic [IN_W-1:0] blk_sum,
    output logic [W-1:0]    y
);
    localparam int DLY = 2;

    typedef struct packed {
        logic [W-1:0]          int1;
        logic [W-1:0]          int2;
        logic [DLY-1:0][W-1:0] hist2;
        logic [DLY-1:0][W-1:0] hist1;
    } s2_t;

    s2_t          s2_d, s2_q;
    logic [W-1:0] x, i1_nx, i2_nx, c1;

    always_comb begin
        s2_d  = s2_q;
        x     = {{(W-IN_W){blk_sum[IN_W-1]}}, blk_sum};
        i1_nx = s2_q.int1 + x;
        i2_nx = s2_q.int2 + i1_nx;
        c1    = i2_nx - s2_q.hist2[DLY-1];
        y     = c1 - s2_q.hist1[DLY-1];
        if (blk_end) begin
            s2_d.int1 = i1_nx;
            s2_d.int2 = i2_nx;
            for (int k = DLY - 1; k > 0; k--) begin
                s2_d.hist2[k] = s2_q.hist2[k-1];
                s2_d.hist1[k] = s2_q.hist1[k-1];
            end
            s2_d.hist2[0] = i2_nx;
            s2_d.hist1[0] = c1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s2_q <= '0;
        else        s2_q <= s2_d;
    end
endmodule

// File: rtl/quad_ddc_1b.sv
module quad_ddc_1b
    import quad_ddc_pkg::*;
#(
    parameter int S1_W = 8,
    parameter int S2_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_bit,
    input  logic             in_valid,
    input  logic [SEL_W-1:0] dec_sel,
    output logic [S2_W-1:0]  i_out,
    output logic [S2_W-1:0]  q_out,
    output logic             out_valid
);
    typedef struct packed {
        logic            valid;
        logic [S2_W-1:0] i;
        logic [S2_W-1:0] q;
    } out_t;

    logic [NUM_BR-1:0] prod_pos;
    logic              blk_end;
    logic [S1_W-1:0]   bsum [NUM_BR];
    logic [S2_W-1:0]   ybr  [NUM_BR];
    out_t              out_d, out_q;

    ddc_lo_mixer u_mix (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_bit   (in_bit),
        .prod_pos (prod_pos)
    );

    ddc_block_ctrl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .dec_sel  (dec_sel),
        .blk_end  (blk_end)
    );

    for (genvar b = 0; b < NUM_BR; b++) begin : g_branch
        ddc_int_dump #(.W(S1_W)) u_s1 (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid),
            .prod_pos (prod_pos[b]),
            .blk_end  (blk_end),
            .blk_sum  (bsum[b])
        );
        ddc_smooth2 #(.IN_W(S1_W), .W(S2_W)) u_s2 (
            .clk     (clk),
            .rst_n   (rst_n),
            .blk_end (blk_end),
            .blk_sum (bsum[b]),
            .y       (ybr[b])
        );
    end

    always_comb begin
        out_d       = out_q;
        out_d.valid = blk_end;
        if (blk_end) begin
            out_d.i = ybr[0];
            out_d.q = ybr[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign i_out     = out_q.i;
    assign q_out     = out_q.q;
    assign out_valid = out_q.valid;
endmodule

// File: rtl/quad_ddc_1b_chk.sv
module quad_ddc_1b_chk
    import quad_ddc_pkg::*;
#(
    parameter int S2_W = 15
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [S2_W-1:0] i_out,
    input logic [S2_W-1:0] q_out,
    input logic            out_valid
);
    localparam int LIM = 4 * MAX_RATIO;

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R5
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    i_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(i_out));

    // R8
    q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(q_out));

    // R7
    out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(i_out) <= LIM && $signed(i_out) >= -LIM &&
                       $signed(q_out) <= LIM && $signed(q_out) >= -LIM));
endmodule

bind quad_ddc_1b quad_ddc_1b_chk #(.S2_W(S2_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .i_out     (i_out),
    .q_out     (q_out),
    .out_valid (out_valid)
);

// File: tb/tb_quad_ddc_1b.sv
module tb_quad_ddc_1b;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_bit = 0;
    logic        in_valid = 0;
    logic [1:0]  dec_sel = 0;
    logic [14:0] i_out, q_out;
    logic        out_valid;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    int m_ph, m_cnt, m_ratio, exp_v, exp_i, exp_q, last_i, last_q;
    int m_acc [2];
    int h0 [2];
    int h1 [2];
    string tag_v, tag_i, tag_q;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    quad_ddc_1b dut (
        .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_valid(in_valid),
        .dec_sel(dec_sel), .i_out(i_out), .q_out(q_out), .out_valid(out_valid)
    );

    function automatic int lo_i_of(int ph); return (ph < 4) ? 1 : 0; endfunction
    function automatic int lo_q_of(int ph); return (ph < 2 || ph >= 6) ? 1 : 0; endfunction

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] sel);
        @(negedge clk);
        rst_n = 0; in_valid = 0; in_bit = 0; dec_sel = sel;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_ph = 0; m_cnt = 0; m_ratio = 4 << sel; exp_v = 0;
        last_i = 0; last_q = 0;
        for (int k = 0; k < 2; k++) begin m_acc[k] = 0; h0[k] = 0; h1[k] = 0; end
        // R1: state held by reset
        chk("R1", int'(out_valid), 0);
        chk("R1", int'($signed(i_out)), 0);
        chk("R1", int'($signed(q_out)), 0);
    endtask

    // check result of the previous cycle, then drive one cycle
    task automatic push(input logic b, input logic v, input logic [1:0] sel);
        int p;
        @(negedge clk);
        chk(tag_v, int'(out_valid), exp_v);
        if (exp_v != 0) begin
            chk(tag_i, int'($signed(i_out)), exp_i);
            chk(tag_q, int'($signed(q_out)), exp_q);
            last_i = exp_i; last_q = exp_q;
        end else begin
            // R8: words hold between strobes
            chk("R8", int'($signed(i_out)), last_i);
            chk("R8", int'($signed(q_out)), last_q);
        end
        in_bit = b; in_valid = v; dec_sel = sel;
        exp_v = 0;
        if (v) begin
            p = (int'(b) == lo_i_of(m_ph)) ? 1 : -1; m_acc[0] += p;
            p = (int'(b) == lo_q_of(m_ph)) ? 1 : -1; m_acc[1] += p;
            m_ph = (m_ph + 1) % 8;
            m_cnt++;
            if (m_cnt == m_ratio) begin
                exp_i = m_acc[0] + 2 * h0[0] + h1[0];
                exp_q = m_acc[1] + 2 * h0[1] + h1[1];
                for (int k = 0; k < 2; k++) begin
                    h1[k] = h0[k]; h0[k] = m_acc[k]; m_acc[k] = 0;
                end
                exp_v = 1; m_cnt = 0; m_ratio = 4 << sel;
            end
        end
    endtask

    // kind 0: in-phase LO copy, 1: quadrature LO copy with gaps,
    // 2: all ones, 3: pseudo-random bits and valids
    task automatic run(int kind, int n, logic [1:0] sel);
        logic b, v;
        for (int t = 0; t < n; t++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            v = 1;
            case (kind)
                0: b = lo_i_of(m_ph) != 0;
                1: begin b = lo_q_of(m_ph) != 0; v = (t % 3) != 2; end
                2: b = 1;
                default: begin b = lfsr[0]; v = lfsr[5] | lfsr[9]; end
            endcase
            push(b, v, sel);
        end
        push(0, 0, sel);
    endtask

    initial begin
        for (int s = 0; s < 4; s++) begin
            tag_v = "R5";
            tag_i = "R2"; tag_q = "R3";
            do_reset(2'(s)); run(0, 160, 2'(s));
            tag_i = "R4"; tag_q = "R4";
            do_reset(2'(s)); run(1, 240, 2'(s));
            tag_i = "R6"; tag_q = "R6";
            do_reset(2'(s)); run(2, 160, 2'(s));
            tag_i = "R7"; tag_q = "R7";
            do_reset(2'(s)); run(3, 600, 2'(s));
        end
        // R9: ratio change mid-block applies from the next block
        tag_v = "R9"; tag_i = "R9"; tag_q = "R9";
        do_reset(2'd0);
        for (int t = 0; t < 6; t++)   push(lfsr[t], 1, 2'd0);
        for (int t = 0; t < 100; t++) push(t[2] ^ t[0], 1, 2'd3);
        for (int t = 0; t < 40; t++)  push(t[1], 1, 2'd1);
        push(0, 0, 2'd1);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule